// File: doc/BRIEF.md
# Serial EEPROM Burst Word Reader

This block is the master side of a three-wire serial EEPROM link with a separate select line. It reads a run of consecutive 16-bit words. The host gives a start address and a word count and pulses `go`. For every word the block raises the select line and sends a full read frame. It then shifts the word in from the device, presents it on `word_data` with a one-cycle `word_valid` strobe, and drops the select line for one serial clock period before the next word. After the last word, `done` pulses for one cycle.

Each serial clock period is a low phase of `LO_CYC` system clocks followed by a high phase of `HI_CYC` system clocks. Both are parameters, so the minimum high and low times of the device, and the hold time of the select line, can be met from any system clock rate. The address field is `ADDR_W` bits wide, 6 for small parts and 8 for larger ones. Addresses advance modulo 2^`ADDR_W`.

Top module: `mwr_burst_read`

## Requirements
- R1: While `rst_n` is low, and after its release until `go`, `mem_sel`, `mem_clk`, `mem_dout`, `word_valid` and `done` are all low.
- R2: Each word's select window starts with one full serial clock period in which `mem_dout` is 0. Each later period carries one frame bit, changing at the start of its low phase: a start bit 1, then opcode bits 1 and 0, then the address, most significant bit first.
- R3: With `ADDR_W` = 8 the frame carries 8 address bits and the reads return the correct words, including a wrap from address 255 to 0.
- R4: The device changes `mem_din` after each rising edge of `mem_clk`. The block samples `mem_din` at the end of every high phase, from the last address period to the end of the window: 17 samples in all. The first sample, a dummy 0, is dropped, and the next 16 form `word_data`, most significant bit first.
- R5: Words are read from `start_addr` through `start_addr + word_count - 1`, modulo 2^`ADDR_W`, with one complete frame per word. `word_valid` is high for exactly one cycle per word, in the first cycle after `mem_sel` falls.
- R6: Between two words of a burst, `mem_sel` is low for exactly `LO_CYC + HI_CYC` system clocks.
- R7: While `mem_sel` is high, every high phase of `mem_clk` lasts `HI_CYC` cycles and every low phase lasts `LO_CYC` cycles. Each select window lasts `(ADDR_W + 20) * (LO_CYC + HI_CYC)` cycles.
- R8: Whenever `mem_sel` is low, `mem_clk` and `mem_dout` are low.
- R9: `done` pulses high for one cycle, `LO_CYC + HI_CYC` cycles after the last word's `word_valid`, exactly once per burst.
- R10: A `go` pulse during a burst is ignored: the running burst's addresses, word count and single `done` are unchanged.
- R11: A `go` with `word_count` = 0 gives `done` in the next cycle, with no activity on `mem_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| go | input | 1 | Start pulse, sampled only while idle |
| start_addr | input | ADDR_W | First word address |
| word_count | input | CNT_W | Number of words to read |
| mem_sel | output | 1 | Device select, active high |
| mem_clk | output | 1 | Serial clock to the device |
| mem_dout | output | 1 | Serial data to the device |
| mem_din | input | 1 | Serial data from the device |
| word_data | output | 16 | Last word read, valid with `word_valid` |
| word_valid | output | 1 | One-cycle strobe per word |
| done | output | 1 | One-cycle pulse at the end of a burst |

## Verification
Every result has a fixed latency. `word_valid` is due in the first cycle after `mem_sel` falls. `done` is due exactly `LO_CYC + HI_CYC` cycles after the last strobe, or one cycle after `go` for a zero count. A select window is exactly `(ADDR_W + 20)` serial periods long and a gap exactly one period. The bench drives inputs and samples outputs on the falling system clock edge. It measures each of these intervals in cycles from the rising-edge count and compares it to the value computed from the parameters. A behavioural device model records every frame it receives, so each strobed word is checked against both its expected address and its expected content.

// File: rtl/mwr_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the serial EEPROM burst reader.
// Assumes the device returns 16-bit words and uses a 2-bit read opcode.
package mwr_pkg;
    localparam int WORD_W   = 16;
    localparam int HDR_BITS = 4;          // setup period + start bit + 2 opcode bits
    localparam logic [2:0] FRAME_HEAD = 3'b110;  // start bit, then read opcode

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEL  = 2'd1,
        ST_GAP  = 2'd2
    } mwr_state_t;
endpackage

// File: rtl/mwr_phase_gen.sv
`timescale 1ns/1ps
// Serial clock phase generator.
// While run is high it produces a low phase of LO_CYC cycles, then a high
// phase of HI_CYC cycles, and repeats. fall_tick marks the last cycle of
// each high phase. Assumes LO_CYC and HI_CYC are both at least 1.
module mwr_phase_gen #(
    parameter int LO_CYC = 50,
    parameter int HI_CYC = 150
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic phase_hi,
    output logic fall_tick
);
    localparam int MAX_CYC = (LO_CYC > HI_CYC) ? LO_CYC : HI_CYC;
    localparam int DIV_W   = $clog2(MAX_CYC + 1);

    logic [DIV_W-1:0] cnt_q;
    logic             hi_q;
    logic             lo_end;

    // End-of-phase decode.
    always_comb begin
        lo_end    = run && !hi_q && (cnt_q == DIV_W'(LO_CYC - 1));
        fall_tick = run &&  hi_q && (cnt_q == DIV_W'(HI_CYC - 1));
    end

    // Phase counter and phase flag.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
            hi_q  <= 1'b0;
        end else if (lo_end) begin
            cnt_q <= '0;
            hi_q  <= 1'b1;
        end else if (fall_tick) begin
            cnt_q <= '0;
            hi_q  <= 1'b0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign phase_hi = hi_q;
endmodule

// File: rtl/mwr_word_capture.sv
`timescale 1ns/1ps
// Serial-to-parallel word capture.
// It shifts din in at every sample. The register is WORD_W wide, so a
// leading extra bit falls off the top. valid pulses in the cycle after the
// sample that is flagged last.
module mwr_word_capture #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample,
    input  logic              last,
    input  logic              din,
    output logic [WORD_W-1:0] word,
    output logic              valid
);
    // Shift register and completion strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word  <= '0;
            valid <= 1'b0;
        end else begin
            valid <= sample && last;
            if (sample) begin
                word <= {word[WORD_W-2:0], din};
            end
        end
    end
endmodule

// File: rtl/mwr_burst_read.sv
`timescale 1ns/1ps
// Serial EEPROM burst word reader (top).
// For each word it raises mem_sel and sends a setup period with data low,
// then the start bit, the read opcode and the address MSB first. It then
// samples 17 bits at the end of the high phases and drops mem_sel for one
// period. go is looked at only while idle.
// Assumes ADDR_W is 6 or 8 and the device drives mem_din after each rise.
module mwr_burst_read
    import mwr_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int CNT_W  = ADDR_W + 1,
    parameter int LO_CYC = 50,
    parameter int HI_CYC = 150
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  word_count,
    output logic              mem_sel,
    output logic              mem_clk,
    output logic              mem_dout,
    input  logic              mem_din,
    output logic [WORD_W-1:0] word_data,
    output logic              word_valid,
    output logic              done
);
    localparam int NBITS  = HDR_BITS + ADDR_W + WORD_W;
    localparam int IDX_W  = $clog2(NBITS);
    localparam int HDR_W  = 3 + ADDR_W;
    localparam int FIRST_SAMPLE = HDR_BITS + ADDR_W - 1;

    mwr_state_t        state_q;
    logic [IDX_W-1:0]  bit_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  remain_q;
    logic [HDR_W-1:0]  hdr_q;
    logic              done_q;

    logic phase_hi, fall_tick, run;
    logic last_bit, sample_en;

    assign run = (state_q != ST_IDLE);

    mwr_phase_gen #(
        .LO_CYC (LO_CYC),
        .HI_CYC (HI_CYC)
    ) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .phase_hi  (phase_hi),
        .fall_tick (fall_tick)
    );

    // Decode of the period within the select window.
    always_comb begin
        last_bit  = (bit_q == IDX_W'(NBITS - 1));
        sample_en = (state_q == ST_SEL) && fall_tick && (bit_q >= IDX_W'(FIRST_SAMPLE));
    end

    // Burst sequencer: frame bits, per-word gap, address step and done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            bit_q    <= '0;
            addr_q   <= '0;
            remain_q <= '0;
            hdr_q    <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (go) begin
                        if (word_count == '0) begin
                            done_q <= 1'b1;
                        end else begin
                            state_q  <= ST_SEL;
                            bit_q    <= '0;
                            addr_q   <= start_addr;
                            remain_q <= word_count;
                            hdr_q    <= {FRAME_HEAD, start_addr};
                        end
                    end
                end
                ST_SEL: begin
                    if (fall_tick) begin
                        if (bit_q != '0) begin
                            hdr_q <= {hdr_q[HDR_W-2:0], 1'b0};
                        end
                        if (last_bit) begin
                            state_q <= ST_GAP;
                            bit_q   <= '0;
                            addr_q  <= addr_q + 1'b1;
                        end else begin
                            bit_q <= bit_q + 1'b1;
                        end
                    end
                end
                ST_GAP: begin
                    if (fall_tick) begin
                        if (remain_q == CNT_W'(1)) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            state_q  <= ST_SEL;
                            remain_q <= remain_q - 1'b1;
                            hdr_q    <= {FRAME_HEAD, addr_q};
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    mwr_word_capture #(
        .WORD_W (WORD_W)
    ) u_capture (
        .clk    (clk),
        .rst_n  (rst_n),
        .sample (sample_en),
        .last   (last_bit),
        .din    (mem_din),
        .word   (word_data),
        .valid  (word_valid)
    );

    // Serial line drive; everything idles low outside the select window.
    always_comb begin
        mem_sel  = (state_q == ST_SEL);
        mem_clk  = mem_sel && phase_hi;
        mem_dout = mem_sel && (bit_q != '0) && hdr_q[HDR_W-1];
    end

    assign done = done_q;
endmodule

// File: rtl/mwr_burst_read_chk.sv
`timescale 1ns/1ps
// Protocol checker for mwr_burst_read, attached by bind.
// It measures phase and window lengths with counters and checks the pulse
// and idle rules at the ports.
module mwr_burst_read_chk #(
    parameter int ADDR_W = 6,
    parameter int LO_CYC = 50,
    parameter int HI_CYC = 150
) (
    input logic clk,
    input logic rst_n,
    input logic mem_sel,
    input logic mem_clk,
    input logic mem_dout,
    input logic word_valid,
    input logic done
);
    localparam int WIN_CYC = (ADDR_W + 20) * (LO_CYC + HI_CYC);

    logic [31:0] hi_run, lo_run, sel_run;

    // Run-length counters for the clock phases and the select window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_run  <= '0;
            lo_run  <= '0;
            sel_run <= '0;
        end else begin
            hi_run  <= mem_clk ? hi_run + 1 : '0;
            lo_run  <= (mem_sel && !mem_clk) ? lo_run + 1 : '0;
            sel_run <= mem_sel ? sel_run + 1 : '0;
        end
    end

    AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_sel |-> (!mem_clk && !mem_dout)) else $error("idle lines");          // R8
    AST_SETUP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_sel) |-> !mem_dout) else $error("setup data");                  // R2
    AST_HIGH_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_clk) |-> (hi_run == HI_CYC)) else $error("high phase");         // R7
    AST_LOW_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_clk) |-> (lo_run == LO_CYC)) else $error("low phase");          // R7
    AST_WINDOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_sel) |-> (sel_run == WIN_CYC)) else $error("window length");    // R7
    AST_VALID_AT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> (!mem_sel && $past(mem_sel))) else $error("valid place");  // R5
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid) else $error("valid width");                   // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("done width");                                // R9
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!mem_sel && !word_valid)) else $error("done overlap");          // R9
endmodule

bind mwr_burst_read mwr_burst_read_chk #(
    .ADDR_W (ADDR_W),
    .LO_CYC (LO_CYC),
    .HI_CYC (HI_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_sel    (mem_sel),
    .mem_clk    (mem_clk),
    .mem_dout   (mem_dout),
    .word_valid (word_valid),
    .done       (done)
);

// File: tb/tb_mwr_burst_read.sv
`timescale 1ns/1ps
// Behavioural serial EEPROM: waits for a start bit, takes the opcode and
// the address, then drives a dummy 0 and 16 data bits, each change
// following a rising serial clock edge.
module mwr_eeprom_model #(
    parameter int AW = 6
) (
    input  logic          sel,
    input  logic          sclk,
    input  logic          mosi,
    output logic          miso,
    output logic [AW-1:0] frame_addr,
    output logic [1:0]    frame_op
);
    int          k;
    bit          started;
    logic [AW+1:0] hdr;
    logic [15:0] w;

    function automatic logic [15:0] content(int a);
        return 16'((a * 40503) ^ (a << 7) ^ 16'h2C5B);
    endfunction

    initial begin
        miso = 1'b0; frame_addr = '0; frame_op = '0;
        k = 0; started = 1'b0; hdr = '0; w = '0;
    end

    always @(negedge sel) begin
        started = 1'b0;
        k = 0;
        miso <= 1'b0;
    end

    always @(posedge sclk) begin
        if (sel) begin
            if (!started) begin
                if (mosi) begin
                    started = 1'b1;
                    k = 0;
                end
            end else if (k < AW + 2) begin
                hdr = {hdr[AW:0], mosi};
                k++;
                if (k == AW + 2) begin
                    frame_op   = hdr[AW+1:AW];
                    frame_addr = hdr[AW-1:0];
                    w          = content(int'(hdr[AW-1:0]));
                    miso <= 1'b0;
                end
            end else if (k < AW + 18) begin
                miso <= w[15 - (k - AW - 2)];
                k++;
            end else begin
                miso <= 1'b0;
            end
        end
    end
endmodule

module tb_mwr_burst_read;
    localparam int LO  = 2;
    localparam int HI  = 3;
    localparam int PER = LO + HI;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    int     n_chk = 0;
    int     n_bad = 0;
    longint cyc = 0;
    always @(posedge clk) cyc++;

    // 6-bit address instance
    logic        go6 = 1'b0;
    logic [5:0]  sa6 = '0;
    logic [6:0]  wc6 = '0;
    logic        sel6, clk6, dout6, din6, val6, done6;
    logic [15:0] data6;
    logic [5:0]  fa6;
    logic [1:0]  fo6;

    mwr_burst_read #(.ADDR_W(6), .CNT_W(7), .LO_CYC(LO), .HI_CYC(HI)) dut (
        .clk(clk), .rst_n(rst_n), .go(go6), .start_addr(sa6), .word_count(wc6),
        .mem_sel(sel6), .mem_clk(clk6), .mem_dout(dout6), .mem_din(din6),
        .word_data(data6), .word_valid(val6), .done(done6));
    mwr_eeprom_model #(.AW(6)) m6 (.sel(sel6), .sclk(clk6), .mosi(dout6),
        .miso(din6), .frame_addr(fa6), .frame_op(fo6));

    // 8-bit address instance
    logic        go8 = 1'b0;
    logic [7:0]  sa8 = '0;
    logic [8:0]  wc8 = '0;
    logic        sel8, clk8, dout8, din8, val8, done8;
    logic [15:0] data8;
    logic [7:0]  fa8;
    logic [1:0]  fo8;

    mwr_burst_read #(.ADDR_W(8), .CNT_W(9), .LO_CYC(LO), .HI_CYC(HI)) dut8 (
        .clk(clk), .rst_n(rst_n), .go(go8), .start_addr(sa8), .word_count(wc8),
        .mem_sel(sel8), .mem_clk(clk8), .mem_dout(dout8), .mem_din(din8),
        .word_data(data8), .word_valid(val8), .done(done8));
    mwr_eeprom_model #(.AW(8)) m8 (.sel(sel8), .sclk(clk8), .mosi(dout8),
        .miso(din8), .frame_addr(fa8), .frame_op(fo8));

    function automatic logic [15:0] expect_word(int a);
        return 16'((a * 40503) ^ (a << 7) ^ 16'h2C5B);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Monitor state for the 6-bit instance
    int     exp6 = 0, got6 = 0, done_cnt6 = 0, idle_bad6 = 0, hrun6 = 0, lrun6 = 0;
    longint last_v6 = 0;
    logic   prev_sel6 = 1'b0;

    // Per-cycle monitor of the 6-bit instance, sampled on the falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (!sel6 && (clk6 || dout6)) idle_bad6++;
            if (val6) begin
                chk(data6 == expect_word(exp6), "R4", "word data", data6, expect_word(exp6));
                chk(fa6 == 6'(exp6), "R5", "frame address", fa6, exp6);
                chk(fo6 == 2'b10, "R2", "frame opcode", fo6, 2);
                exp6 = (exp6 + 1) % 64;
                got6++;
                last_v6 = cyc;
            end
            if (done6) begin
                done_cnt6++;
                if (got6 > 0) chk(cyc - last_v6 == PER, "R9", "done latency", cyc - last_v6, PER);
            end
            if (sel6 && !prev_sel6 && got6 > 0 && done_cnt6 == 0)
                chk(lrun6 == PER, "R6", "gap length", lrun6, PER);
            if (!sel6 && prev_sel6)
                chk(hrun6 == 26 * PER, "R7", "select window", hrun6, 26 * PER);
            hrun6 = sel6 ? hrun6 + 1 : 0;
            lrun6 = sel6 ? 0 : lrun6 + 1;
            prev_sel6 = sel6;
        end
    end

    int exp8 = 0, got8 = 0, done_cnt8 = 0;

    // Word monitor of the 8-bit instance.
    always @(negedge clk) begin
        if (rst_n) begin
            if (val8) begin
                chk(data8 == expect_word(exp8), "R3", "word data (8-bit)", data8, expect_word(exp8));
                chk(fa8 == 8'(exp8), "R3", "frame address (8-bit)", fa8, exp8);
                exp8 = (exp8 + 1) % 256;
                got8++;
            end
            if (done8) done_cnt8++;
        end
    end

    task automatic burst6(input int start, input int count, input bit interfere);
        exp6 = start; got6 = 0; done_cnt6 = 0;
        @(negedge clk);
        sa6 = 6'(start); wc6 = 7'(count); go6 = 1'b1;
        @(negedge clk);
        go6 = 1'b0;
        if (interfere) begin
            repeat (200) @(negedge clk);
            sa6 = 6'd17; wc6 = 7'd9; go6 = 1'b1;   // R10: ignored while busy
            @(negedge clk);
            go6 = 1'b0;
        end
        for (int i = 0; i < 20000 && done_cnt6 == 0; i++) @(negedge clk);
        repeat (3 * PER) @(negedge clk);
        chk(got6 == count, interfere ? "R10" : "R5", "word count", got6, count);
        chk(done_cnt6 == 1, interfere ? "R10" : "R9", "done pulses", done_cnt6, 1);
    endtask

    task automatic burst8(input int start, input int count);
        exp8 = start; got8 = 0; done_cnt8 = 0;
        @(negedge clk);
        sa8 = 8'(start); wc8 = 9'(count); go8 = 1'b1;
        @(negedge clk);
        go8 = 1'b0;
        for (int i = 0; i < 20000 && done_cnt8 == 0; i++) @(negedge clk);
        repeat (3 * PER) @(negedge clk);
        chk(got8 == count, "R3", "word count (8-bit)", got8, count);
        chk(done_cnt8 == 1, "R3", "done pulses (8-bit)", done_cnt8, 1);
    endtask

    task automatic zero6();
        int sel_seen;
        sel_seen = 0; got6 = 0; done_cnt6 = 0;
        @(negedge clk);
        sa6 = 6'd9; wc6 = 7'd0; go6 = 1'b1;
        @(negedge clk);
        go6 = 1'b0;
        chk(done6 == 1'b1, "R11", "done after zero count", done6, 1);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (sel6 || done6) sel_seen++;
        end
        chk(sel_seen == 0, "R11", "activity after zero count", sel_seen, 0);
        chk(done_cnt6 == 1, "R11", "done pulses", done_cnt6, 1);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Main sequence.
    initial begin
        repeat (4) @(negedge clk);
        chk({sel6, clk6, dout6, val6, done6} == 5'b0, "R1", "outputs in reset", {sel6, clk6, dout6, val6, done6}, 0);
        chk({sel8, clk8, dout8, val8, done8} == 5'b0, "R1", "outputs in reset (8-bit)", {sel8, clk8, dout8, val8, done8}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk({sel6, clk6, dout6, val6, done6} == 5'b0, "R1", "outputs after reset", {sel6, clk6, dout6, val6, done6}, 0);

        burst6(0, 64, 1'b0);
        burst6(62, 4, 1'b0);
        burst6(5, 1, 1'b0);
        burst6(33, 1, 1'b0);
        burst6(63, 1, 1'b0);
        burst6(10, 3, 1'b1);
        zero6();
        burst8(254, 3);
        burst8(8'hA5, 2);

        chk(idle_bad6 == 0, "R8", "lines active while deselected", idle_bad6, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule